// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block takes a stereo serial audio stream made of a bit clock, a word clock and one data line. It recovers one left and one right sample per frame. The three pins run slower than the system clock. They pass through a two-flop synchronizer, and the block finds rising edges of the bit clock on the system clock. Four framing formats are supported: standard I2S, left-justified, right-justified and short frame-sync PCM. The sample width and the frame length are chosen at run time.

A mix stage sits after the receiver. For each output channel it picks that channel's own sample, the opposite channel's sample, or the average of the two. Both outputs are sign-extended to 32 bits and update together with a one-cycle valid strobe once per frame. A framing-error flag shows whether the most recent frame had the bit-clock count that the frame-size setting calls for.

Top module: `audioSerialRx`

## Requirements
- R1: With format code 00 (standard I2S), a low word clock marks the left channel. A channel's MSB arrives on the second bit-clock rising edge at or after the word-clock transition that opens the channel. The left channel starts at the falling transition and the right channel at the rising transition.
- R2: With format code 01 (left-justified), a high word clock marks the left channel. The MSB arrives on the first bit-clock rising edge after the word clock rises (left) or falls (right).
- R3: With format code 10 (right-justified), a high word clock marks the left channel. The LSB arrives on the last bit-clock rising edge before the word clock changes level, so unused leading slot bits are ignored.
- R4: With format code 11 (PCM), the frame sync is a high pulse one bit clock wide. The left MSB arrives on the next bit clock. The right MSB follows the left LSB on the very next bit clock.
- R5: Size code 00/01/10/11 selects 16/20/24/32 bits per sample. Data is sent MSB first and sampled on the bit-clock rising edge. Each sample is sign-extended from its top received bit to 32 bits.
- R6: Frame select bit 2 chooses 2 slots (0) or 4 slots (1) per word-clock period. Bits 1:0 select the slot width with the same coding as the size code. The bit clocks per frame are slots × slot width: 32, 40, 48, 64, 64, 80, 96 or 128.
- R7: `sampleValid` is high for exactly one system clock per completed frame. `leftOut` and `rightOut` change only in a cycle where `sampleValid` is high.
- R8: Mix code 00 routes the channel's own sample, 01 routes the opposite channel's sample, and 10 or 11 routes floor((left + right) / 2) of the sign-extended samples.
- R9: At every frame start after the first one since reset, `frameErr` becomes 1 if the number of bit clocks since the previous frame start differs from the configured frame length, and 0 otherwise. It holds its value until the next frame start.
- R10: Reset clears `leftOut`, `rightOut`, `sampleValid` and `frameErr` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| bclkPin | input | 1 | Serial bit clock |
| wclkPin | input | 1 | Word clock or frame sync |
| dinPin | input | 1 | Serial data |
| fmtSel | input | 2 | Framing format code |
| sizeSel | input | 2 | Sample size code |
| frameSel | input | 3 | Slot count (bit 2) and slot width code (bits 1:0) |
| mixLSel | input | 2 | Mix code for the left output |
| mixRSel | input | 2 | Mix code for the right output |
| leftOut | output | 32 | Left output sample, sign-extended |
| rightOut | output | 32 | Right output sample, sign-extended |
| sampleValid | output | 1 | One-cycle strobe when a new sample pair is presented |
| frameErr | output | 1 | Last frame length did not match the configured ratio |

## Verification
The assertions take the format, size, frame and mix selects as static while frames are flowing. They also assume the slot width is at least the sample width, and that each bit-clock phase lasts at least three system clocks so the synchronizer sees every edge. The stimulus changes configuration only while reset is held. It drives each bit-clock phase for four system clocks and changes data and word clock only while the bit clock is low. Every vector it sends has a slot width equal to or larger than the sample size.

// File: rtl/audRxPkg.sv
package audRxPkg;

  typedef enum logic [1:0] {
    FMT_I2S = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_RJ  = 2'b10,
    FMT_PCM = 2'b11
  } fmtE;

  // strobes from the framing control to the sample datapath
  typedef struct packed {
    logic shiftL;
    logic shiftR;
    logic bitVal;
    logic frameDone;
  } rxStrobeT;

  function automatic logic [7:0] codeBits(input logic [1:0] code);
    case (code)
      2'b00:   return 8'd16;
      2'b01:   return 8'd20;
      2'b10:   return 8'd24;
      default: return 8'd32;
    endcase
  endfunction

endpackage

// File: rtl/audRxCtrl.sv
module audRxCtrl
  import audRxPkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           bclkPin,
  input  logic           wclkPin,
  input  logic           dinPin,
  input  logic [1:0]     fmtSel,
  input  logic [1:0]     sizeSel,
  input  logic [2:0]     frameSel,
  output rxStrobeT       strb,
  output logic           frameErr
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [SYNC_N:0]   bSh;
  logic [SYNC_N-1:0] wSh;
  logic [SYNC_N-1:0] dSh;
  logic              bitEdge;
  logic              wNow;
  logic              dNow;
  logic              wD1;
  logic              wD2;
  logic [CNT_W-1:0]  cnt;
  logic              armed;
  logic [CNT_W-1:0]  slotW;
  logic [CNT_W-1:0]  ratio;
  logic [CNT_W-1:0]  half;
  logic [CNT_W-1:0]  size;
  logic [CNT_W-1:0]  lStart;
  logic [CNT_W-1:0]  rStart;
  logic              startHit;
  logic              frameStart;
  logic [CNT_W-1:0]  posNow;
  logic              inL;
  logic              inR;
  fmtE               fmt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bSh <= '0;
      wSh <= '0;
      dSh <= '0;
    end else begin
      bSh <= {bSh[SYNC_N-1:0], bclkPin};
      wSh <= {wSh[SYNC_N-2:0], wclkPin};
      dSh <= {dSh[SYNC_N-2:0], dinPin};
    end
  end

  assign bitEdge = bSh[SYNC_N-1] & ~bSh[SYNC_N];
  assign wNow    = wSh[SYNC_N-1];
  assign dNow    = dSh[SYNC_N-1];

  assign fmt   = fmtE'(fmtSel);
  assign slotW = CNT_W'(codeBits(frameSel[1:0]));
  assign ratio = frameSel[2] ? (slotW << 2) : (slotW << 1);
  assign half  = ratio >> 1;
  assign size  = CNT_W'(codeBits(sizeSel));

  // frame start and channel windows on a timeline where position 0 is the left MSB
  always_comb begin
    case (fmt)
      FMT_I2S: begin
        startHit = ~wD1 & wD2;
        lStart   = '0;
        rStart   = half;
      end
      FMT_LJ: begin
        startHit = wNow & ~wD1;
        lStart   = '0;
        rStart   = half;
      end
      FMT_RJ: begin
        startHit = wNow & ~wD1;
        lStart   = half - size;
        rStart   = ratio - size;
      end
      default: begin
        startHit = wD1 & ~wD2;
        lStart   = '0;
        rStart   = size;
      end
    endcase
  end

  assign frameStart = bitEdge & startHit;
  assign posNow     = frameStart ? '0 : cnt;
  assign inL        = (posNow >= lStart) && (posNow < lStart + size);
  assign inR        = (posNow >= rStart) && (posNow < rStart + size);

  assign strb.shiftL    = bitEdge & inL;
  assign strb.shiftR    = bitEdge & inR;
  assign strb.bitVal    = dNow;
  assign strb.frameDone = bitEdge & armed & (posNow == ratio - ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wD1      <= 1'b0;
      wD2      <= 1'b0;
      cnt      <= '0;
      armed    <= 1'b0;
      frameErr <= 1'b0;
    end else if (bitEdge) begin
      wD1   <= wNow;
      wD2   <= wD1;
      cnt   <= (posNow == CNT_MAX) ? CNT_MAX : posNow + ONE;
      armed <= armed | frameStart;
      if (frameStart && armed) frameErr <= (cnt != ratio);
    end
  end

endmodule

// File: rtl/audRxData.sv
module audRxData
  import audRxPkg::*;
#(
  parameter int SMP_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxStrobeT         strb,
  input  logic [1:0]       sizeSel,
  input  logic [1:0]       mixLSel,
  input  logic [1:0]       mixRSel,
  output logic [SMP_W-1:0] leftOut,
  output logic [SMP_W-1:0] rightOut,
  output logic             sampleValid
);

  localparam int NCH = 2;

  logic [SMP_W-1:0] shReg [NCH];
  logic [SMP_W-1:0] smp   [NCH];
  logic [SMP_W-1:0] mixed [NCH];
  logic             doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg[0] <= '0;
      shReg[1] <= '0;
      doneQ    <= 1'b0;
    end else begin
      if (strb.shiftL) shReg[0] <= {shReg[0][SMP_W-2:0], strb.bitVal};
      if (strb.shiftR) shReg[1] <= {shReg[1][SMP_W-2:0], strb.bitVal};
      doneQ <= strb.frameDone;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : gCh
    logic [SMP_W:0] sum;
    logic [1:0]     sel;

    always_comb begin
      case (sizeSel)
        2'b00:   smp[c] = {{(SMP_W-16){shReg[c][15]}}, shReg[c][15:0]};
        2'b01:   smp[c] = {{(SMP_W-20){shReg[c][19]}}, shReg[c][19:0]};
        2'b10:   smp[c] = {{(SMP_W-24){shReg[c][23]}}, shReg[c][23:0]};
        default: smp[c] = shReg[c];
      endcase
    end

    assign sel = (c == 0) ? mixLSel : mixRSel;
    assign sum = {smp[c][SMP_W-1], smp[c]} + {smp[NCH-1-c][SMP_W-1], smp[NCH-1-c]};

    always_comb begin
      case (sel)
        2'b00:   mixed[c] = smp[c];
        2'b01:   mixed[c] = smp[NCH-1-c];
        default: mixed[c] = sum[SMP_W:1];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leftOut     <= '0;
      rightOut    <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= doneQ;
      if (doneQ) begin
        leftOut  <= mixed[0];
        rightOut <= mixed[1];
      end
    end
  end

endmodule

// File: rtl/audioSerialRx.sv
module audioSerialRx
  import audRxPkg::*;
#(
  parameter int SMP_W  = 32,
  parameter int CNT_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bclkPin,
  input  logic             wclkPin,
  input  logic             dinPin,
  input  logic [1:0]       fmtSel,
  input  logic [1:0]       sizeSel,
  input  logic [2:0]       frameSel,
  input  logic [1:0]       mixLSel,
  input  logic [1:0]       mixRSel,
  output logic [SMP_W-1:0] leftOut,
  output logic [SMP_W-1:0] rightOut,
  output logic             sampleValid,
  output logic             frameErr
);

  rxStrobeT strb;

  audRxCtrl #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .bclkPin  (bclkPin),
    .wclkPin  (wclkPin),
    .dinPin   (dinPin),
    .fmtSel   (fmtSel),
    .sizeSel  (sizeSel),
    .frameSel (frameSel),
    .strb     (strb),
    .frameErr (frameErr)
  );

  audRxData #(.SMP_W(SMP_W)) data_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .sizeSel     (sizeSel),
    .mixLSel     (mixLSel),
    .mixRSel     (mixRSel),
    .leftOut     (leftOut),
    .rightOut    (rightOut),
    .sampleValid (sampleValid)
  );

endmodule

// File: rtl/audRxChk.sv
module audRxChk #(
  parameter int SMP_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       sizeSel,
  input logic [1:0]       mixLSel,
  input logic [1:0]       mixRSel,
  input logic [SMP_W-1:0] leftOut,
  input logic [SMP_W-1:0] rightOut,
  input logic             sampleValid
);

  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  a_r7_left_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(leftOut) |-> sampleValid);

  a_r7_right_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rightOut) |-> sampleValid);

  a_r5_sign_ext16: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && sizeSel == 2'b00) |->
      (leftOut[SMP_W-1:15] == {(SMP_W-15){leftOut[15]}}) &&
      (rightOut[SMP_W-1:15] == {(SMP_W-15){rightOut[15]}}));

  a_r8_avg_match: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && mixLSel[1] && mixRSel[1]) |-> (leftOut == rightOut));

  a_r8_other_match: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && mixLSel == 2'b01 && mixRSel == 2'b00) |-> (leftOut == rightOut));

endmodule

bind audioSerialRx audRxChk #(.SMP_W(SMP_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .sizeSel     (sizeSel),
  .mixLSel     (mixLSel),
  .mixRSel     (mixRSel),
  .leftOut     (leftOut),
  .rightOut    (rightOut),
  .sampleValid (sampleValid)
);

// File: tb/audioSerialRx_tb_top.sv
module audioSerialRx_tb_top;

  typedef struct packed {
    logic [1:0]  fmt;
    logic [1:0]  sz;
    logic [2:0]  fr;
    logic [1:0]  ml;
    logic [1:0]  mr;
    logic [31:0] l;
    logic [31:0] r;
  } vecT;

  localparam int NVEC = 8;
  localparam vecT VEC [NVEC] = '{
    '{2'b00, 2'b00, 3'b000, 2'b00, 2'b00, 32'h00008001, 32'h00007FFE}, // R1 R5
    '{2'b01, 2'b01, 3'b001, 2'b00, 2'b00, 32'h000FFFFF, 32'h00012345}, // R2
    '{2'b10, 2'b10, 3'b110, 2'b00, 2'b00, 32'h00800000, 32'h00000001}, // R3 R6
    '{2'b11, 2'b11, 3'b011, 2'b00, 2'b00, 32'hDEADBEEF, 32'h01234567}, // R4
    '{2'b10, 2'b00, 3'b011, 2'b01, 2'b00, 32'h0000ABCD, 32'h00001234}, // R3 R8
    '{2'b00, 2'b10, 3'b110, 2'b01, 2'b01, 32'h00123456, 32'h00FEDCBA}, // R1 R6 R8
    '{2'b01, 2'b00, 3'b100, 2'b10, 2'b10, 32'h00007FFF, 32'h00000001}, // R2 R8
    '{2'b11, 2'b00, 3'b111, 2'b11, 2'b00, 32'h0000FFFD, 32'h00000000}  // R4 R6 R8
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bclkPin = 1'b0;
  logic        wclkPin = 1'b0;
  logic        dinPin = 1'b0;
  logic [1:0]  fmtSel = 2'b00;
  logic [1:0]  sizeSel = 2'b00;
  logic [2:0]  frameSel = 3'b000;
  logic [1:0]  mixLSel = 2'b00;
  logic [1:0]  mixRSel = 2'b00;
  logic [31:0] leftOut;
  logic [31:0] rightOut;
  logic        sampleValid;
  logic        frameErr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  int vcnt = 0;
  logic [31:0] capL [4];
  logic [31:0] capR [4];

  int nBits, ratioB, halfB, lsB, rsB;
  logic [31:0] curL, curR;
  logic carry;

  always #10 clk = ~clk;

  audioSerialRx dut_i (
    .clk (clk), .rstN (rstN), .bclkPin (bclkPin), .wclkPin (wclkPin), .dinPin (dinPin),
    .fmtSel (fmtSel), .sizeSel (sizeSel), .frameSel (frameSel),
    .mixLSel (mixLSel), .mixRSel (mixRSel),
    .leftOut (leftOut), .rightOut (rightOut), .sampleValid (sampleValid), .frameErr (frameErr)
  );

  always @(negedge clk) begin
    if (rstN && sampleValid) begin
      if (vcnt < 4) begin
        capL[vcnt] = leftOut;
        capR[vcnt] = rightOut;
      end
      vcnt = vcnt + 1;
    end
  end

  function automatic int bitsOf(input logic [1:0] c);
    return (c == 2'b00) ? 16 : (c == 2'b01) ? 20 : (c == 2'b10) ? 24 : 32;
  endfunction

  function automatic logic [31:0] sx(input logic [31:0] v, input int n);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = (i < n) ? v[i] : v[n-1];
    return r;
  endfunction

  function automatic logic [31:0] mixOf(input logic [1:0] sel, input logic [31:0] own,
                                        input logic [31:0] oth);
    logic signed [32:0] s;
    if (sel == 2'b00) return own;
    if (sel == 2'b01) return oth;
    s = $signed({own[31], own}) + $signed({oth[31], oth});
    s = s >>> 1;
    return s[31:0];
  endfunction

  function automatic logic bitAt(input int p);
    if (p >= lsB && p < lsB + nBits) return curL[nBits-1-(p-lsB)];
    if (p >= rsB && p < rsB + nBits) return curR[nBits-1-(p-rsB)];
    return 1'b0;
  endfunction

  function automatic logic wireW(input int k);
    case (fmtSel)
      2'b00:   return (k < halfB) ? 1'b0 : 1'b1;
      2'b11:   return (k == 0);
      default: return (k < halfB) ? 1'b1 : 1'b0;
    endcase
  endfunction

  function automatic bit delayedFmt();
    return (fmtSel == 2'b00) || (fmtSel == 2'b11);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic w, input logic d);
    wclkPin = w;
    dinPin  = d;
    repeat (4) @(negedge clk);
    bclkPin = 1'b1;
    repeat (4) @(negedge clk);
    bclkPin = 1'b0;
  endtask

  task automatic configure(input logic [1:0] f, input logic [1:0] s, input logic [2:0] fr,
                           input logic [1:0] ml, input logic [1:0] mr);
    rstN = 1'b0; bclkPin = 1'b0; wclkPin = 1'b0; dinPin = 1'b0;
    fmtSel = f; sizeSel = s; frameSel = fr; mixLSel = ml; mixRSel = mr;
    nBits  = bitsOf(s);
    ratioB = (fr[2] ? 4 : 2) * bitsOf(fr[1:0]);
    halfB  = ratioB / 2;
    case (f)
      2'b10:   begin lsB = halfB - nBits; rsB = ratioB - nBits; end
      2'b11:   begin lsB = 0; rsB = nBits; end
      default: begin lsB = 0; rsB = halfB; end
    endcase
    carry = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    vcnt = 0;
    sendBit((f == 2'b00) ? 1'b1 : 1'b0, 1'b0); // preamble: level opposite to frame start
  endtask

  task automatic sendFrame(input logic [31:0] l, input logic [31:0] r, input int len);
    curL = l;
    curR = r;
    for (int k = 0; k < len; k++) begin
      if (delayedFmt()) sendBit(wireW(k), (k == 0) ? carry : bitAt(k - 1));
      else              sendBit(wireW(k), bitAt(k));
    end
    carry = bitAt(len - 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check(leftOut == 32'd0, "R10 leftOut in reset", leftOut, 32'd0);
    check(rightOut == 32'd0, "R10 rightOut in reset", rightOut, 32'd0);
    check(sampleValid == 1'b0, "R10 sampleValid in reset", {31'd0, sampleValid}, 32'd0);
    check(frameErr == 1'b0, "R10 frameErr in reset", {31'd0, frameErr}, 32'd0);

    // table-driven frames: R1..R8, R9 clean frames
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] sL, sR, eL, eR;
      configure(VEC[v].fmt, VEC[v].sz, VEC[v].fr, VEC[v].ml, VEC[v].mr);
      sendFrame(VEC[v].l, VEC[v].r, ratioB);
      sendFrame(VEC[v].r, VEC[v].l, ratioB);
      if (delayedFmt()) sendBit(wireW(0), carry);
      repeat (12) @(negedge clk);
      sL = sx(VEC[v].l, nBits);
      sR = sx(VEC[v].r, nBits);
      check(vcnt == 2, $sformatf("R7 strobe count vec%0d", v), 32'(vcnt), 32'd2);
      eL = mixOf(VEC[v].ml, sL, sR);
      eR = mixOf(VEC[v].mr, sR, sL);
      check(capL[0] == eL, $sformatf("R1-fmt/R5/R8 left frame A vec%0d", v), capL[0], eL);
      check(capR[0] == eR, $sformatf("R5/R8 right frame A vec%0d", v), capR[0], eR);
      eL = mixOf(VEC[v].ml, sR, sL);
      eR = mixOf(VEC[v].mr, sL, sR);
      check(capL[1] == eL, $sformatf("R6/R8 left frame B vec%0d", v), capL[1], eL);
      check(capR[1] == eR, $sformatf("R6/R8 right frame B vec%0d", v), capR[1], eR);
      check(frameErr == 1'b0, $sformatf("R9 no error vec%0d", v), {31'd0, frameErr}, 32'd0);
    end

    // R10: reset clears outputs holding a nonzero sample
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(leftOut == 32'd0, "R10 leftOut cleared", leftOut, 32'd0);
    check(rightOut == 32'd0, "R10 rightOut cleared", rightOut, 32'd0);

    // R9: short frame flags an error, a correct frame clears it
    configure(2'b01, 2'b00, 3'b000, 2'b00, 2'b00);
    sendFrame(32'h1111, 32'h2222, ratioB - 1);
    sendFrame(32'h3333, 32'h4444, ratioB);
    repeat (12) @(negedge clk);
    check(frameErr == 1'b1, "R9 short frame flagged", {31'd0, frameErr}, 32'd1);
    check(vcnt == 1, "R7 no strobe for short frame", 32'(vcnt), 32'd1);
    sendFrame(32'h5555, 32'h6666, ratioB);
    repeat (12) @(negedge clk);
    check(frameErr == 1'b0, "R9 correct frame clears flag", {31'd0, frameErr}, 32'd0);
    check(capL[1] == 32'h00005555, "R2 left after recovery", capL[1], 32'h00005555);
    sendFrame(32'h7777, 32'h0001, ratioB + 1);
    sendFrame(32'h0002, 32'h0003, ratioB);
    repeat (12) @(negedge clk);
    check(frameErr == 1'b1, "R9 long frame flagged", {31'd0, frameErr}, 32'd1);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(frameErr == 1'b0, "R10 reset clears frameErr", {31'd0, frameErr}, 32'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule